// File: doc/BRIEF.md
# IEEE Rounding Decision Unit

This unit finishes rounding for a floating-point datapath. Its input is a normalized mantissa with two extra low-order bits: guard at bit 1 and round at bit 0. A separate sticky bit, the sign of the value and a 2-bit rounding-mode code come with it. The unit removes guard and round with a right shift of two, then decides whether to add one to what is left. If it adds one, the carry runs the full width of the mantissa. The outputs are the rounded mantissa, a round-up flag and an inexact flag.

If the increment carries out of a mantissa of all ones, the result is 2.0. The unit does not renormalize it. The carry-out bit is the top bit of the output, and the round-up flag is also set, so the consumer can adjust the exponent.

A separate output, `ovf_to_inf`, tells the consumer what to do if its result overflows: become infinity (1) or become the largest finite magnitude (0). The choice depends only on the mode and the sign.

The rounding logic is combinational. It sits behind a valid/ready stage, and a parameter picks one of two forms for that stage:
- `REG_OUT = 1` (default) puts one register slice on the output. A result appears one cycle after the input is accepted. `in_ready` is high when the slice is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the slice holds its result unchanged and refuses new input.
- `REG_OUT = 0` is a pass-through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

The mode code and sign are control pins and travel with the data beat.

Top module: `rnd_unit`

## Requirements
- R1: When no increment is made, `out_mant` equals the input mantissa shifted right by two, with the top (carry) bit zero.
- R2: When guard, round and sticky are all zero, `out_up` is 0, `out_inexact` is 0 and the mantissa is unchanged, in every mode.
- R3: `out_inexact` is 1 whenever guard (input bit 1), round (input bit 0) or sticky is 1, in every mode.
- R4: In mode 0 (nearest, ties to even), an increment is made exactly when guard is 1 and at least one of round, sticky or the shifted mantissa's LSB (input bit 2) is 1.
- R5: In mode 1 (toward zero), no increment is ever made.
- R6: In mode 2 (toward plus infinity), an increment is made exactly when the result is inexact and the sign is 0. In mode 3 (toward minus infinity), an increment is made exactly when the result is inexact and the sign is 1.
- R7: An increment adds one with full carry. A shifted mantissa of all ones rounds to `out_mant` with only its top bit set, and `out_up` is 1.
- R8: `ovf_to_inf` depends on the mode and the sign as follows:
  - mode 0: always 1
  - mode 1: always 0
  - mode 2: 1 only when the sign is 0
  - mode 3: 1 only when the sign is 1
- R9: With the output register, a result appears one cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs stay stable.
- R10: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_mant | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) |
| in_sticky | input | 1 | OR of all bits below round |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_mant | output | MANT_W+1 | Rounded mantissa; the top bit is the carry-out |
| out_up | output | 1 | An increment was made |
| out_inexact | output | 1 | Guard, round or sticky was nonzero |
| ovf_to_inf | output | 1 | An overflow should become infinity, not the largest finite value |

## Verification
The bench uses a 4-bit mantissa and sweeps every combination of the 6-bit input mantissa, sticky, sign and mode.

The exact patterns (guard, round and sticky all zero) separate correct truncation from spurious increments. The patterns with guard set and round and sticky clear are the ties; by varying the LSB they distinguish ties-to-even from ties-away. The all-ones mantissas with guard set exercise the full carry into the 2.0 result. Flipping the sign under the directed modes shows that the direction of rounding follows the sign.

A separate stall sequence holds `out_ready` low across a queued second beat, to confirm that the result is held and that input is refused while the output is stalled.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_NINF = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic [MANT_W+1:0] mant_in,
  input  logic              sticky,
  input  logic              sign,
  input  logic [1:0]        mode,
  output logic [MANT_W-1:0] trunc,
  output logic              bump,
  output logic              inexact,
  output logic              ovf_inf
);
  logic g_bit, r_bit, lsb;

  assign trunc = mant_in[MANT_W+1:2];
  assign g_bit = mant_in[1];
  assign r_bit = mant_in[0];
  assign lsb   = mant_in[2];

  always_comb begin
    inexact = g_bit | r_bit | sticky;
    bump    = 1'b0;
    ovf_inf = 1'b1;
    case (rnd_mode_e'(mode))
      RM_NEAR: begin
        bump    = g_bit & (r_bit | sticky | lsb);
        ovf_inf = 1'b1;
      end
      RM_ZERO: begin
        bump    = 1'b0;
        ovf_inf = 1'b0;
      end
      RM_PINF: begin
        bump    = inexact & ~sign;
        ovf_inf = ~sign;
      end
      RM_NINF: begin
        bump    = inexact & sign;
        ovf_inf = sign;
      end
      default: begin
        bump    = 1'b0;
        ovf_inf = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W          = 24,
  parameter int BLK        = 8,
  parameter bit USE_BLOCKS = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W:0]   sum
);
  generate
    if (!USE_BLOCKS) begin : g_flat
      assign sum = {1'b0, a} + {{W{1'b0}}, cin};
    end else begin : g_blk
      localparam int NB = (W + BLK - 1) / BLK;
      localparam int PW = NB * BLK;
      logic [PW-1:0] pa, ps;
      logic [NB:0]   c;
      assign pa   = PW'(a);
      assign c[0] = cin;
      for (genvar b = 0; b < NB; b++) begin : g_b
        assign ps[b*BLK +: BLK] = pa[b*BLK +: BLK] + BLK'(c[b]);
        assign c[b+1]           = c[b] & (&pa[b*BLK +: BLK]);
      end
      if (PW == W) begin : g_exact
        assign sum = {c[NB], ps[W-1:0]};
      end else begin : g_pad
        assign sum = ps[W:0];
      end
    end
  endgenerate
endmodule

// File: rtl/rnd_stage.sv
module rnd_stage #(
  parameter int PW      = 28,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          vq;
      logic [PW-1:0] dq;
      assign in_ready  = !vq || out_ready;
      assign out_valid = vq;
      assign out_data  = dq;
      always_ff @(posedge clk) begin
        if (!rst_n) vq <= 1'b0;
        else if (in_ready) vq <= in_valid;
      end
      always_ff @(posedge clk) begin
        if (in_valid && in_ready) dq <= in_data;
      end

      // R9
      hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      // R9
      refuse_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_pass
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W     = 24,
  parameter int BLK        = 8,
  parameter bit USE_BLOCKS = 1'b1,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MANT_W+1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MANT_W:0]   out_mant,
  output logic              out_up,
  output logic              out_inexact,
  output logic              ovf_to_inf
);
  localparam int PW = MANT_W + 4;

  logic [MANT_W-1:0] trunc;
  logic              bump, inexact, ovf_inf;
  logic [MANT_W:0]   sum;
  logic [PW-1:0]     pay_in, pay_out;
  logic              acc;

  rnd_decide #(.MANT_W(MANT_W)) u_decide (
    .mant_in (in_mant),
    .sticky  (in_sticky),
    .sign    (in_sign),
    .mode    (in_mode),
    .trunc   (trunc),
    .bump    (bump),
    .inexact (inexact),
    .ovf_inf (ovf_inf)
  );

  rnd_incr #(.W(MANT_W), .BLK(BLK), .USE_BLOCKS(USE_BLOCKS)) u_incr (
    .a   (trunc),
    .cin (bump),
    .sum (sum)
  );

  assign pay_in = {sum, bump, inexact, ovf_inf};

  rnd_stage #(.PW(PW), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_mant    = pay_out[PW-1:3];
  assign out_up      = pay_out[2];
  assign out_inexact = pay_out[1];
  assign ovf_to_inf  = pay_out[0];

  assign acc = in_valid && in_ready;

  // R2
  exact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mant[1:0] == 2'b00 && !in_sticky) |-> (!inexact && !bump && sum[MANT_W-1:0] == in_mant[MANT_W+1:2]));
  // R5
  rz_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'd1) |-> (!bump && sum[MANT_W] == 1'b0));
  // R6
  dir_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bump && in_mode[1]) |-> (in_sign == in_mode[0]));
  // R7
  carry_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sum[MANT_W]) |-> (bump && (&in_mant[MANT_W+1:2]) && sum[MANT_W-1:0] == '0));
  // R3
  inexact_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mant[1] || in_mant[0] || in_sticky)) |-> inexact);
endmodule

// File: tb/rnd_unit_bench.sv
module rnd_unit_bench;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [MW+1:0] in_mant = '0;
  logic          in_sticky = 1'b0;
  logic          in_sign = 1'b0;
  logic [1:0]    in_mode = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [MW:0]   out_mant;
  logic          out_up, out_inexact, ovf_to_inf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rnd_unit #(.MANT_W(MW), .BLK(3), .USE_BLOCKS(1'b1), .REG_OUT(1'b1)) u_rnd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mant(in_mant), .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_mant(out_mant),
    .out_up(out_up), .out_inexact(out_inexact), .ovf_to_inf(ovf_to_inf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected values from the requirements, computed arithmetically.
  task automatic expect_of(input logic [MW+1:0] v, input bit s, input bit sg, input int md,
                           output int e_mant, output bit e_up, output bit e_inx, output bit e_inf);
    int m;
    bit g, r;
    m = int'(v >> 2);
    g = v[1];
    r = v[0];
    e_inx = g | r | s;
    case (md)
      0: begin e_up = g & (r | s | v[2]); e_inf = 1'b1; end
      1: begin e_up = 1'b0;               e_inf = 1'b0; end
      2: begin e_up = e_inx & !sg;        e_inf = !sg;  end
      default: begin e_up = e_inx & sg;   e_inf = sg;   end
    endcase
    e_mant = m + int'(e_up);
  endtask

  task automatic check_out(input logic [MW+1:0] v, input bit s, input bit sg, input int md);
    int e_mant;
    bit e_up, e_inx, e_inf;
    string t_up, t_m;
    expect_of(v, s, sg, md, e_mant, e_up, e_inx, e_inf);
    t_up = (md == 0) ? "R4 nearest-even" : (md == 1) ? "R5 toward-zero" : "R6 directed";
    t_m  = (e_mant == (1 << MW)) ? "R7 full carry" : (e_up ? "R7 increment" : "R1 truncate");
    chk(out_valid == 1'b1, "R9 valid after one cycle", int'(out_valid), 1);
    chk(out_up == e_up, t_up, int'(out_up), int'(e_up));
    chk(int'(out_mant) == e_mant, t_m, int'(out_mant), e_mant);
    chk(out_inexact == e_inx, e_inx ? "R3 inexact" : "R2 exact", int'(out_inexact), int'(e_inx));
    chk(ovf_to_inf == e_inf, "R8 overflow direction", int'(ovf_to_inf), int'(e_inf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 valid low in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10 ready high in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid low after reset", int'(out_valid), 0);

    // Exhaustive sweep
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int s = 0; s < 2; s++)
          for (int v = 0; v < (1 << (MW + 2)); v++) begin
            in_valid  = 1'b1;
            in_mant   = (MW+2)'(v);
            in_sticky = s[0];
            in_sign   = sg[0];
            in_mode   = md[1:0];
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check_out((MW+2)'(v), s[0], sg[0], md);
          end

    // R9: stall holds the result and refuses a queued beat
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_mant = 6'b111110; in_sticky = 1'b0; in_sign = 1'b0; in_mode = 2'd0;
    @(posedge clk);
    @(negedge clk);
    in_mant = 6'b000101; in_sticky = 1'b1; in_sign = 1'b1; in_mode = 2'd3;
    chk(in_ready == 1'b0, "R9 ready low while stalled", int'(in_ready), 0);
    check_out(6'b111110, 1'b0, 1'b0, 0);
    @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 still refusing", int'(in_ready), 0);
    check_out(6'b111110, 1'b0, 1'b0, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(6'b000101, 1'b1, 1'b1, 3);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drains when idle", int'(out_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule